// File: doc/BRIEF.md
# Converter Soft-Start Sequencer

This block paces the startup of a switching regulator in switching-clock periods. It does not use absolute time. It stays idle until the bias supply reports that it is above its lockout level and the enable input is high. It then spends a short qualification window sampling the feedback-divider status flags. After that window it lets a digital reference code climb by one step for each switching-clock tick. The analog side turns the code into the soft-start reference. The block itself only produces digital control.

Three milestones are decoded from the climbing code:

- **In regulation** marks the point where the ramp equals the nominal reference.
- **Synchronous rectification allowed** comes a little earlier, at 95 % of that level. Until then the low-side switch stays out of full synchronous mode, so a pre-charged output is not pulled down.
- **Fault latch enabled** comes last, at the 1.0 V equivalent. Until then, undervoltage protection and the power-good high state are held off.

A shorted divider seen during qualification freezes the sequencer with the ramp at zero. An open divider still lets the ramp run, but an undervoltage fault flag is raised when the last milestone arrives. Losing bias or dropping enable clears the ramp and the sequence. An external fault input parks the block with the ramp cleared until enable is cycled.

Top module: `softstart_seq`

## Requirements
- R1: The ramp stays at 0 and every flag stays low unless `bias_ok` and `en` are both high.
- R2: After `bias_ok` and `en` are both high, one idle clock passes. Then `CHECK_TICKS` ticks (default 16) are consumed with the ramp held at 0 before the ramp starts counting.
- R3: Once released, `ramp_code` rises by exactly 1 on each clock where `tick` is high. It is unchanged on other clocks and saturates at `LATCH_CODE` (default 4000, i.e. 1.0 V equivalent).
- R4: `in_reg` is high exactly when `ramp_code >= REG_CODE` (default 3200).
- R5: `sync_ok` is high exactly when `ramp_code >= SYNC_CODE` (default 3040), which is never later than `in_reg`.
- R6: `latch_en` is high exactly when `ramp_code == LATCH_CODE`.
- R7: If `fb_short` is high on any clock of the qualification window, `fb_short_lock` goes high and the ramp stays at 0. This holds even after `fb_short` clears, until `bias_ok` or `en` drops.
- R8: If `fb_open` is high during the qualification window, the ramp still runs. `fb_uv_fault` goes high together with `latch_en` and stays high with it.
- R9: `bias_ok` or `en` low on a clock clears the ramp, `fb_short_lock` and the sequence on that edge. A later rise restarts from R2.
- R10: `fault_in` high, while bias and enable are present, clears the ramp and flags on that edge. The ramp stays at 0, whatever the ticks, until `en` has gone low and high again.
- R11: `fb_open` and `fb_short` have no effect once the ramp has been released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bias_ok | input | 1 | Bias supply above lockout |
| en | input | 1 | Enable request |
| tick | input | 1 | One-clock pulse per switching period |
| fb_open | input | 1 | Feedback divider detected open |
| fb_short | input | 1 | Feedback divider detected shorted |
| fault_in | input | 1 | Protection fault latch set |
| ramp_code | output | CODE_W | Soft-start reference code |
| in_reg | output | 1 | Ramp at or above regulation point |
| sync_ok | output | 1 | Full synchronous rectification allowed |
| fb_uv_fault | output | 1 | Open-divider undervoltage fault |
| latch_en | output | 1 | Fault latch and power-good enabled |
| fb_short_lock | output | 1 | Start blocked by shorted divider |

## Verification
The ramp is driven with several tick patterns: a tick on every clock, every second, third and fourth clock, and an irregular pattern. A model counts the ticks delivered, and each pattern is followed to saturation. This separates counting on ticks from counting on clocks, and exposes off-by-one errors in the qualification length and in each milestone threshold.

Divider faults are placed inside the qualification window and, separately, after release. This shows whether the block latches the open or short state only where it should. Enable drops, bias drops and fault pulses are applied in mid-ramp, and in the fault case enable is held high afterwards. This distinguishes a plain clear from the "no restart until enable cycles" behaviour.

// File: rtl/softstart_seq.sv
module softstart_seq #(
  parameter int CODE_W      = 12,
  parameter int CHECK_TICKS = 16,
  parameter int SYNC_CODE   = 3040,
  parameter int REG_CODE    = 3200,
  parameter int LATCH_CODE  = 4000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bias_ok,
  input  logic              en,
  input  logic              tick,
  input  logic              fb_open,
  input  logic              fb_short,
  input  logic              fault_in,
  output logic [CODE_W-1:0] ramp_code,
  output logic              in_reg,
  output logic              sync_ok,
  output logic              fb_uv_fault,
  output logic              latch_en,
  output logic              fb_short_lock
);

  localparam int CHK_W = $clog2(CHECK_TICKS + 1);
  localparam logic [CODE_W-1:0] TOP  = CODE_W'(LATCH_CODE);
  localparam logic [CODE_W-1:0] LAST = CODE_W'(LATCH_CODE - 1);
  localparam logic [CHK_W-1:0]  CHK_LAST = CHK_W'(CHECK_TICKS - 1);

  typedef enum logic [2:0] {
    S_IDLE, S_CHECK, S_RAMP, S_DONE, S_BLOCK, S_HALT
  } state_t;

  state_t            st;
  logic [CODE_W-1:0] ramp;
  logic [CHK_W-1:0]  chk;
  logic              open_seen;
  logic              go;

  assign go = bias_ok & en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      ramp      <= '0;
      chk       <= '0;
      open_seen <= 1'b0;
    end else if (!go) begin
      st        <= S_IDLE;
      ramp      <= '0;
      chk       <= '0;
      open_seen <= 1'b0;
    end else if (fault_in) begin
      st   <= S_HALT;
      ramp <= '0;
      chk  <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          st        <= S_CHECK;
          chk       <= '0;
          open_seen <= 1'b0;
        end
        S_CHECK: begin
          if (fb_short) begin
            st <= S_BLOCK;
          end else begin
            if (fb_open) open_seen <= 1'b1;
            if (tick) begin
              if (chk == CHK_LAST) begin
                st  <= S_RAMP;
                chk <= '0;
              end else begin
                chk <= chk + 1'b1;
              end
            end
          end
        end
        S_RAMP: begin
          if (tick) begin
            ramp <= ramp + 1'b1;
            if (ramp == LAST) st <= S_DONE;
          end
        end
        default: ;
      endcase
    end
  end

  assign ramp_code     = ramp;
  assign in_reg        = ramp >= CODE_W'(REG_CODE);
  assign sync_ok       = ramp >= CODE_W'(SYNC_CODE);
  assign latch_en      = ramp == TOP;
  assign fb_uv_fault   = open_seen & latch_en;
  assign fb_short_lock = st == S_BLOCK;

  // R3
  ramp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ramp_code > $past(ramp_code)) |-> (ramp_code == $past(ramp_code) + 1'b1) && $past(tick));

  // R3
  ramp_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ramp_code <= TOP);

  // R5
  sync_before_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_reg |-> sync_ok);

  // R7
  short_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fb_short_lock |-> ramp_code == '0);

  // R8
  uv_with_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fb_uv_fault |-> latch_en);

  // R9
  drop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bias_ok && en) |=> (ramp_code == '0) && !fb_short_lock);

  // R10
  fault_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_in && bias_ok && en) |=> ramp_code == '0);

endmodule

// File: tb/softstart_seq_bench.sv
module softstart_seq_bench;
  localparam int CW = 8, CK = 4, SY = 30, RG = 32, LT = 40;

  logic clk = 0, rst_n = 0;
  logic bias_ok = 0, en = 0, tick = 0, fb_open = 0, fb_short = 0, fault_in = 0;
  logic [CW-1:0] ramp_code;
  logic in_reg, sync_ok, fb_uv_fault, latch_en, fb_short_lock;

  softstart_seq #(.CODE_W(CW), .CHECK_TICKS(CK), .SYNC_CODE(SY), .REG_CODE(RG),
                  .LATCH_CODE(LT)) u_softstart_seq (
    .clk(clk), .rst_n(rst_n), .bias_ok(bias_ok), .en(en), .tick(tick),
    .fb_open(fb_open), .fb_short(fb_short), .fault_in(fault_in),
    .ramp_code(ramp_code), .in_reg(in_reg), .sync_ok(sync_ok),
    .fb_uv_fault(fb_uv_fault), .latch_en(latch_en), .fb_short_lock(fb_short_lock));

  always #10 clk = ~clk;

  int checks = 0, errors = 0, nt = 0;
  bit live = 0, exp_open = 0, exp_lock = 0, finished = 0;

  task automatic cmp(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic check_all(input string tag);
    int r;
    r = live ? nt - CK : 0;
    if (r < 0) r = 0;
    if (r > LT) r = LT;
    cmp({tag, " R3 ramp"}, ramp_code, r);
    cmp({tag, " R4 in_reg"}, in_reg, r >= RG);
    cmp({tag, " R5 sync_ok"}, sync_ok, r >= SY);
    cmp({tag, " R6 latch_en"}, latch_en, r == LT);
    cmp({tag, " R8 uv"}, fb_uv_fault, exp_open && r == LT);
    cmp({tag, " R7 lock"}, fb_short_lock, exp_lock);
  endtask

  function automatic bit pick(input int mode, input int i);
    if (mode == 0) return ((i * 7) % 5) < 2;
    return (i % mode) == 0;
  endfunction

  task automatic cycles(input int n, input int mode, input string tag);
    for (int i = 0; i < n; i++) begin
      tick = pick(mode, i);
      @(posedge clk);
      if (tick && live) nt++;
      @(negedge clk);
      check_all(tag);
    end
  endtask

  task automatic start();
    tick = 0; bias_ok = 1; en = 1;
    @(posedge clk);
    @(negedge clk);
    nt = 0; live = 1;
  endtask

  task automatic stop();
    en = 0; live = 0; exp_lock = 0; exp_open = 0;
    cycles(1, 1, "R9 stop");
  endtask

  task automatic run_full(input int mode, input string tag);
    int guard = 0;
    while (nt < CK + LT + 3 && guard < 1000) begin
      cycles(1, mode == 0 ? 0 : 1, tag);
      if (mode > 1) cycles(mode - 1, 99999, tag);
      guard++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    check_all("R1 reset");
    rst_n = 1;
    // R1: enable without bias, and bias without enable
    en = 1; cycles(20, 1, "R1 no-bias");
    en = 0; bias_ok = 1; cycles(20, 1, "R1 no-en");
    bias_ok = 0;
    cycles(2, 1, "R1 idle");
    // R2 R3 R4 R5 R6: sweep of tick patterns
    for (int m = 0; m <= 4; m++) begin
      start();
      run_full(m, $sformatf("R2 mode%0d", m));
      cycles(5, 1, "R3 sat");
      stop();
    end
    // R8: open divider during the check window
    fb_open = 1; exp_open = 1;
    start(); run_full(1, "R8 open");
    fb_open = 0; stop();
    // R7: shorted divider
    fb_short = 1; start(); live = 0; exp_lock = 1;
    cycles(2, 1, "R7 enter");
    cycles(60, 1, "R7 held");
    fb_short = 0; cycles(20, 1, "R7 after clear");
    stop();
    start(); run_full(1, "R9 restart after lock");
    stop();
    // R11: feedback flags after release
    start();
    while (nt < CK + 3) cycles(1, 1, "R11 pre");
    fb_open = 1; fb_short = 1;
    run_full(2, "R11 ignored");
    fb_open = 0; fb_short = 0; stop();
    // R9: enable drop and bias drop mid-ramp
    start(); while (nt < CK + 20) cycles(1, 1, "R9 pre");
    en = 0; live = 0; cycles(1, 1, "R9 en drop");
    start(); while (nt < CK + 35) cycles(1, 1, "R9 pre2");
    bias_ok = 0; live = 0; cycles(1, 1, "R9 bias drop");
    cycles(5, 1, "R9 bias low");
    start(); run_full(3, "R9 restart");
    stop();
    // R10: fault mid-ramp, no restart until enable cycles
    start(); while (nt < CK + 25) cycles(1, 1, "R10 pre");
    fault_in = 1; live = 0; cycles(1, 1, "R10 fault");
    fault_in = 0; cycles(80, 1, "R10 held");
    stop();
    start(); run_full(1, "R10 restart");
    stop();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule